// File: doc/BRIEF.md
# Snapshot Statistics Counter Bank

This block keeps running event counters for a small group of switch ports and shows software a frozen copy of them instead of the moving values. Each port has a frame counter for received broadcasts and three byte accumulators: received good bytes, received bad bytes and transmitted bytes. The MAC logic outside the block reports events as single-cycle strobes, and byte events carry a length. Every strobe adds to the live counters.

A function register takes commands. A capture command copies every port's live counters into shadow registers on a single clock edge, so all ports share one instant. A flush command clears both the live and the shadow counters. After either command a busy flag stays set for a fixed number of cycles. While busy is set, further writes to the function register have no effect. Software reads the shadow values through a 32-bit, address-decoded read port. Each port has its own window, and each 64-bit accumulator fills two consecutive words.

Top module: `stat_snap_bank`

## Requirements
- R1: After reset, every live and shadow counter is zero, busy is 0, and the function register reads 0x00000000.
- R2: For each port, a broadcast strobe adds 1 to the 32-bit broadcast counter. A good-receive or bad-receive strobe adds that port's receive length to the matching 64-bit accumulator. A transmit strobe adds the port's transmit length to the transmit accumulator. The ports are independent of each other.
- R3: The command code is held in bits 31:24 of a function-register write at address 0x80. Code 1 is flush and code 3 is capture. Any other code starts no command, and busy stays 0.
- R4: Busy (bit 17 of the function register, and the `busy` output) is 1 for exactly NUM_PORTS+1 cycles after the edge that accepts a command. While busy is 1, bits 31:24 read back the running command code.
- R5: A capture copies the live counters of all ports into the shadow registers on the edge that accepts it. A strobe in that same cycle reaches the live counter but not the snapshot. The snapshot does not change until the next capture or flush.
- R6: A flush zeroes the live and shadow counters of all ports on the edge that accepts it. Strobes in that same cycle are lost. Strobes in later cycles are counted.
- R7: A function-register write made while busy is 1 is ignored completely. It does not start a command, it does not change the timer or enable fields, and it does not lengthen the busy period.
- R8: Bits 15:0 (timer) and bit 16 (half-full enable) take their values from any function-register write made while busy is 0, and they read back unchanged.
- R9: Port n's snapshot window starts at address 0x20000 + n*0x100. The offsets inside the window are 0x00 for broadcasts, 0x3C/0x40 for good bytes, 0x44/0x48 for bad bytes and 0x84/0x88 for transmitted bytes. The lower address holds the low word.
- R10: A read from an offset not listed in R9, from a port index of NUM_PORTS or higher, or from an address outside the windows and the function register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 32 | Read data (combinational from rd_addr) |
| ev_rx_bcast | input | NUM_PORTS | Per-port received-broadcast strobe |
| ev_rx_good | input | NUM_PORTS | Per-port good-frame receive strobe |
| ev_rx_bad | input | NUM_PORTS | Per-port bad-frame receive strobe |
| ev_tx | input | NUM_PORTS | Per-port transmit strobe |
| rx_len | input | NUM_PORTS*LEN_W | Per-port receive byte length |
| tx_len | input | NUM_PORTS*LEN_W | Per-port transmit byte length |
| busy | output | 1 | Command in progress |

## Verification
A strobe or a command takes effect on the rising edge where it is sampled. The counters and busy then show the new state in the following cycle, and read data follows the read address within the same cycle. The bench drives every input on the falling edge and gives each task one rising edge to complete. It samples outputs shortly after a falling edge, so each check looks at the state one edge after its stimulus. Busy is counted by falling edges starting just after the accepting edge, and the count must equal NUM_PORTS+1. The same-cycle cases are driven in the cycle that carries the command: a strobe alongside a capture, a strobe alongside a flush, and a write while busy.

// File: rtl/stat_snap_pkg.sv
package stat_snap_pkg;

  localparam logic [7:0] CODE_FLUSH   = 8'd1;
  localparam logic [7:0] CODE_CAPTURE = 8'd3;

  localparam logic [7:0] OFS_BCAST   = 8'h00;
  localparam logic [7:0] OFS_GOOD_LO = 8'h3C;
  localparam logic [7:0] OFS_GOOD_HI = 8'h40;
  localparam logic [7:0] OFS_BAD_LO  = 8'h44;
  localparam logic [7:0] OFS_BAD_HI  = 8'h48;
  localparam logic [7:0] OFS_TX_LO   = 8'h84;
  localparam logic [7:0] OFS_TX_HI   = 8'h88;

  // Choose one 32-bit word out of a port's snapshot, given the offset in its window.
  function automatic logic [31:0] pick_word(input logic [7:0] ofs, input logic [63:0] bc,
                                            input logic [63:0] good, input logic [63:0] bad,
                                            input logic [63:0] txb);
    case (ofs)
      OFS_BCAST:   pick_word = bc[31:0];
      OFS_GOOD_LO: pick_word = good[31:0];
      OFS_GOOD_HI: pick_word = good[63:32];
      OFS_BAD_LO:  pick_word = bad[31:0];
      OFS_BAD_HI:  pick_word = bad[63:32];
      OFS_TX_LO:   pick_word = txb[31:0];
      OFS_TX_HI:   pick_word = txb[63:32];
      default:     pick_word = 32'h0;
    endcase
  endfunction

  function automatic logic is_command(input logic [7:0] code);
    is_command = (code == CODE_FLUSH) || (code == CODE_CAPTURE);
  endfunction

endpackage

// File: rtl/stat_cmd_ctrl.sv
module stat_cmd_ctrl
  import stat_snap_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_write,
  input  logic [31:0] wr_data,
  output logic        busy,
  output logic        cap_pulse,
  output logic        flush_pulse,
  output logic [7:0]  run_code,
  output logic        half_en_q,
  output logic [15:0] timer_q
);
  localparam int BUSY_LEN = NUM_PORTS + 1;
  localparam int CNT_W    = $clog2(BUSY_LEN + 1);

  logic [CNT_W-1:0] busy_cnt;
  logic             accept;
  logic [7:0]       code;
  logic             unused_bit;

  assign code        = wr_data[31:24];
  assign unused_bit  = ^wr_data[23:17];
  assign accept      = cmd_write && !busy;
  assign busy        = (busy_cnt != '0);
  assign cap_pulse   = accept && (code == CODE_CAPTURE);
  assign flush_pulse = accept && (code == CODE_FLUSH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt  <= '0;
      run_code  <= '0;
      half_en_q <= 1'b0;
      timer_q   <= '0;
    end else if (accept) begin
      timer_q   <= wr_data[15:0];
      half_en_q <= wr_data[16];
      if (is_command(code)) begin
        busy_cnt <= CNT_W'(BUSY_LEN);
        run_code <= code;
      end
    end else if (busy) begin
      busy_cnt <= busy_cnt - 1'b1;
      if (busy_cnt == CNT_W'(1)) run_code <= '0;
    end
  end
endmodule

// File: rtl/stat_port_slice.sv
module stat_port_slice #(
  parameter int FRM_W  = 32,
  parameter int BYTE_W = 64,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              capture,
  input  logic              ev_bcast,
  input  logic              ev_good,
  input  logic              ev_bad,
  input  logic              ev_tx,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic [LEN_W-1:0]  tx_len,
  output logic [FRM_W-1:0]  snap_bcast,
  output logic [BYTE_W-1:0] snap_good,
  output logic [BYTE_W-1:0] snap_bad,
  output logic [BYTE_W-1:0] snap_tx
);
  logic [FRM_W-1:0]  live_bcast;
  logic [BYTE_W-1:0] live_good, live_bad, live_tx;

  function automatic logic [BYTE_W-1:0] add_bytes(input logic [BYTE_W-1:0] cur,
                                                  input logic en, input logic [LEN_W-1:0] amt);
    add_bytes = en ? cur + BYTE_W'(amt) : cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      live_bcast <= '0;
      live_good  <= '0;
      live_bad   <= '0;
      live_tx    <= '0;
      snap_bcast <= '0;
      snap_good  <= '0;
      snap_bad   <= '0;
      snap_tx    <= '0;
    end else begin
      live_bcast <= live_bcast + FRM_W'(ev_bcast);
      live_good  <= add_bytes(live_good, ev_good, rx_len);
      live_bad   <= add_bytes(live_bad, ev_bad, rx_len);
      live_tx    <= add_bytes(live_tx, ev_tx, tx_len);
      if (capture) begin
        snap_bcast <= live_bcast;
        snap_good  <= live_good;
        snap_bad   <= live_bad;
        snap_tx    <= live_tx;
      end
    end
  end
endmodule

// File: rtl/stat_snap_bank.sv
module stat_snap_bank
  import stat_snap_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int FRM_W     = 32,
  parameter int BYTE_W    = 64,
  parameter int LEN_W     = 16,
  parameter int ADDR_W    = 18
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [31:0]                wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [31:0]                rd_data,
  input  logic [NUM_PORTS-1:0]       ev_rx_bcast,
  input  logic [NUM_PORTS-1:0]       ev_rx_good,
  input  logic [NUM_PORTS-1:0]       ev_rx_bad,
  input  logic [NUM_PORTS-1:0]       ev_tx,
  input  logic [NUM_PORTS*LEN_W-1:0] rx_len,
  input  logic [NUM_PORTS*LEN_W-1:0] tx_len,
  output logic                       busy
);
  localparam logic [ADDR_W-1:0]    FUNC_ADDR = ADDR_W'('h80);
  localparam logic [ADDR_W-17:0]   WIN_TAG   = (ADDR_W-16)'(2);
  localparam int                   SLICE_W   = FRM_W + 3 * BYTE_W;
  localparam int                   SNAP_W    = NUM_PORTS * SLICE_W;

  logic              cmd_write, cap_pulse, flush_pulse, half_en_q;
  logic [7:0]        run_code;
  logic [15:0]       timer_q;
  logic [31:0]       func_word;
  logic [SNAP_W-1:0] snap_flat;

  logic [FRM_W-1:0]  snap_bcast [NUM_PORTS];
  logic [BYTE_W-1:0] snap_good  [NUM_PORTS];
  logic [BYTE_W-1:0] snap_bad   [NUM_PORTS];
  logic [BYTE_W-1:0] snap_tx    [NUM_PORTS];

  assign cmd_write = wr_en && (wr_addr == FUNC_ADDR);
  assign func_word = {run_code, 6'b0, busy, half_en_q, timer_q};

  stat_cmd_ctrl #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_write(cmd_write), .wr_data(wr_data),
    .busy(busy), .cap_pulse(cap_pulse), .flush_pulse(flush_pulse),
    .run_code(run_code), .half_en_q(half_en_q), .timer_q(timer_q)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    stat_port_slice #(.FRM_W(FRM_W), .BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_slice (
      .clk(clk), .rst_n(rst_n), .flush(flush_pulse), .capture(cap_pulse),
      .ev_bcast(ev_rx_bcast[p]), .ev_good(ev_rx_good[p]), .ev_bad(ev_rx_bad[p]),
      .ev_tx(ev_tx[p]),
      .rx_len(rx_len[p*LEN_W +: LEN_W]), .tx_len(tx_len[p*LEN_W +: LEN_W]),
      .snap_bcast(snap_bcast[p]), .snap_good(snap_good[p]),
      .snap_bad(snap_bad[p]), .snap_tx(snap_tx[p])
    );
    assign snap_flat[p*SLICE_W +: SLICE_W] = {snap_bcast[p], snap_good[p], snap_bad[p], snap_tx[p]};
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == FUNC_ADDR) begin
      rd_data = func_word;
    end else if (rd_addr[ADDR_W-1:16] == WIN_TAG) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (rd_addr[15:8] == 8'(p))
          rd_data = pick_word(rd_addr[7:0], 64'(snap_bcast[p]), 64'(snap_good[p]),
                              64'(snap_bad[p]), 64'(snap_tx[p]));
      end
    end
  end
endmodule

// File: rtl/stat_snap_chk.sv
module stat_snap_chk #(
  parameter int NUM_PORTS = 2,
  parameter int SNAP_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              cmd_write,
  input logic [31:0]       wr_data,
  input logic              cap_pulse,
  input logic              flush_pulse,
  input logic              half_en_q,
  input logic [15:0]       timer_q,
  input logic [SNAP_W-1:0] snap_flat
);
  logic [7:0] run_cnt;
  logic       is_cmd;

  assign is_cmd = (wr_data[31:24] == 8'd1) || (wr_data[31:24] == 8'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) run_cnt <= '0;
    else        run_cnt <= busy ? run_cnt + 1'b1 : 8'd0;
  end

  a_r3_cmd_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_write && !busy && is_cmd |=> busy);
  a_r3_other_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_write && !busy && !is_cmd |=> !busy);
  a_r4_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_cnt == 8'(NUM_PORTS + 1));
  a_r4_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_cnt <= 8'(NUM_PORTS));
  a_r5_snapshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_pulse && !flush_pulse |=> $stable(snap_flat));
  a_r6_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |=> snap_flat == '0);
  a_r7_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_write |=> $stable({half_en_q, timer_q}));
  a_r7_no_pulse_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cap_pulse && !flush_pulse);
endmodule

bind stat_snap_bank stat_snap_chk #(.NUM_PORTS(NUM_PORTS), .SNAP_W(SNAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_write(cmd_write), .wr_data(wr_data),
  .cap_pulse(cap_pulse), .flush_pulse(flush_pulse), .half_en_q(half_en_q),
  .timer_q(timer_q), .snap_flat(snap_flat)
);

// File: tb/stat_snap_bank_test.sv
module stat_snap_bank_test;
  localparam int NP = 2;
  localparam int LW = 16;
  localparam int AW = 18;

  typedef struct packed {
    logic [7:0]  port;
    logic [7:0]  reps;
    logic [15:0] rxl;
    logic [15:0] txl;
    logic        bad;
    logic [31:0] exp_bc;
    logic [31:0] exp_rx;
    logic [31:0] exp_tx;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{8'd0, 8'd5, 16'd64,    16'd100,   1'b0, 32'd5, 32'd320,   32'd500},
    '{8'd1, 8'd3, 16'd1518,  16'd60,    1'b0, 32'd3, 32'd4554,  32'd180},
    '{8'd1, 8'd4, 16'd1000,  16'd0,     1'b1, 32'd4, 32'd4000,  32'd0},
    '{8'd0, 8'd1, 16'd65535, 16'd65535, 1'b0, 32'd1, 32'd65535, 32'd65535}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [NP-1:0] ev_rx_bcast, ev_rx_good, ev_rx_bad, ev_tx;
  logic [NP*LW-1:0] rx_len, tx_len;
  logic busy;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stat_snap_bank #(.NUM_PORTS(NP), .LEN_W(LW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ev_rx_bcast(ev_rx_bcast),
    .ev_rx_good(ev_rx_good), .ev_rx_bad(ev_rx_bad), .ev_tx(ev_tx),
    .rx_len(rx_len), .tx_len(tx_len), .busy(busy)
  );

  function automatic logic [AW-1:0] win(input int port, input logic [7:0] ofs);
    win = AW'(32'h20000 + port * 32'h100 + int'(ofs));
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    ev_rx_bcast = '0; ev_rx_good = '0; ev_rx_bad = '0; ev_tx = '0;
  endtask

  task automatic put_func(input logic [31:0] d);
    wr_en = 1'b1; wr_addr = AW'('h80); wr_data = d;
  endtask

  task automatic put_ev(input int port, input bit bc, input bit good, input bit bad, input bit tx,
                        input logic [15:0] rl, input logic [15:0] tl);
    ev_rx_bcast[port] = bc; ev_rx_good[port] = good; ev_rx_bad[port] = bad; ev_tx[port] = tx;
    rx_len[port*LW +: LW] = rl; tx_len[port*LW +: LW] = tl;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic command(input logic [31:0] d);
    put_func(d);
    step();
    wait_idle();
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int cnt;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    ev_rx_bcast = '0; ev_rx_good = '0; ev_rx_bad = '0; ev_tx = '0; rx_len = '0; tx_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(AW'('h80), d); check("R1 func reg", d, 32'h0);
    check("R1 busy", 32'(busy), 32'h0);
    rd(win(1, 8'h84), d); check("R1 snapshot", d, 32'h0);

    // R8 timer and enable readback; R3 code 0 starts nothing
    put_func(32'h0001_2345); step();
    check("R3 nop busy", 32'(busy), 32'h0);
    rd(AW'('h80), d); check("R8 readback", d, 32'h0001_2345);
    put_func(32'h0200_0000); step();
    check("R3 code2 busy", 32'(busy), 32'h0);
    rd(AW'('h80), d); check("R8 rewrite", d, 32'h0);

    // Vector table: R2, R9
    foreach (VECS[i]) begin
      command(32'h0100_0000);
      for (int r = 0; r < int'(VECS[i].reps); r++) begin
        put_ev(int'(VECS[i].port), 1'b1, !VECS[i].bad, VECS[i].bad, 1'b1, VECS[i].rxl, VECS[i].txl);
        step();
      end
      command(32'h0300_0000);
      rd(win(int'(VECS[i].port), 8'h00), d); check("R2 bcast", d, VECS[i].exp_bc);
      rd(win(int'(VECS[i].port), VECS[i].bad ? 8'h44 : 8'h3C), d); check("R9 rx low", d, VECS[i].exp_rx);
      rd(win(int'(VECS[i].port), VECS[i].bad ? 8'h48 : 8'h40), d); check("R9 rx high", d, 32'h0);
      rd(win(int'(VECS[i].port), VECS[i].bad ? 8'h3C : 8'h44), d); check("R2 other rx", d, 32'h0);
      rd(win(int'(VECS[i].port), 8'h84), d); check("R9 tx low", d, VECS[i].exp_tx);
      rd(win(1 - int'(VECS[i].port), 8'h00), d); check("R2 other port", d, 32'h0);
    end

    // R4 busy length and command readback
    put_func(32'h0300_0000); step();
    rd(AW'('h80), d); check("R4 running code", d, 32'h0302_0000);
    cnt = 0;
    while (busy && cnt < 20) begin cnt++; @(negedge clk); end
    check("R4 busy cycles", 32'(cnt), 32'(NP + 1));

    // R5 same-cycle strobe excluded, snapshot holds
    command(32'h0100_0000);
    repeat (2) begin put_ev(0, 1, 0, 0, 0, 0, 0); step(); end
    put_ev(0, 1, 0, 0, 0, 0, 0); put_func(32'h0300_0000); step(); wait_idle();
    rd(win(0, 8'h00), d); check("R5 same-cycle capture", d, 32'd2);
    repeat (3) begin put_ev(0, 1, 0, 0, 0, 0, 0); step(); end
    rd(win(0, 8'h00), d); check("R5 snapshot hold", d, 32'd2);
    command(32'h0300_0000);
    rd(win(0, 8'h00), d); check("R5 later capture", d, 32'd6);

    // R10 unmapped reads while port 0 holds nonzero data
    rd(win(NP, 8'h00), d); check("R10 port out of range", d, 32'h0);
    rd(win(0, 8'h04), d); check("R10 unmapped offset", d, 32'h0);
    rd(AW'('h30000), d); check("R10 outside windows", d, 32'h0);

    // R6 flush with same-cycle strobe
    put_ev(0, 1, 0, 0, 0, 0, 0); put_func(32'h0100_0000); step();
    rd(win(0, 8'h00), d); check("R6 shadow cleared", d, 32'h0);
    wait_idle();
    command(32'h0300_0000);
    rd(win(0, 8'h00), d); check("R6 live cleared, strobe dropped", d, 32'h0);
    put_ev(0, 1, 0, 0, 0, 0, 0); step();
    command(32'h0300_0000);
    rd(win(0, 8'h00), d); check("R6 counts after flush", d, 32'd1);

    // R7 write while busy is ignored
    put_func(32'h0300_0000); step();
    cnt = 1;
    put_func(32'h0101_ABCD); step();
    while (busy && cnt < 20) begin cnt++; @(negedge clk); end
    check("R7 busy not extended", 32'(cnt), 32'(NP + 1));
    rd(AW'('h80), d); check("R7 fields unchanged", d, 32'h0);
    rd(win(0, 8'h00), d); check("R7 no flush", d, 32'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule